// File: doc/BRIEF.md
# Four-Register Address Register Bank

The block holds four 16-bit address registers: a program counter, a stack pointer and two index pointers. Each can count up or down by itself, so no arithmetic unit is needed to step through memory or walk a stack. Values move in and out a byte at a time over an 8-bit data bus. The full 16-bit value can also be driven onto an address bus.

A 10-bit control word steers the bank each cycle. It has two independent halves. The output half picks a source register and one of four actions, all decoded combinationally:
- drive the high byte onto the data bus,
- drive the low byte onto the data bus,
- drive the whole value onto the address bus,
- clear the register.

The input half picks a destination register and one of four actions taken on the rising clock edge: load the high byte, load the low byte, increment or decrement. The two halves are decoded separately. When the bank itself drives the data bus, the driven byte is the load source, so one byte can be copied to any other byte in a single clock, even within the same register. The buses are modelled as value plus enable, not as tri-state pins.

Top module: `addr_reg_bank`

## Requirements
- R1: While `rst` is high at a rising edge, every register is set to 0000.
- R2: Output function 00 with a valid source sets `dbus_oe` to 1 and `dbus_out` to that register's bits 15:8. `abus_oe` stays 0.
- R3: Output function 01 with a valid source sets `dbus_oe` to 1 and `dbus_out` to that register's bits 7:0. `abus_oe` stays 0.
- R4: Output function 10 with a valid source sets `abus_oe` to 1 and `abus_out` to the full 16-bit value. `dbus_oe` stays 0. The two enables are never both 1.
- R5: Register codes are 001 = program counter, 010 = stack pointer, 011 = first index, 100 = second index. Codes 000 and 101 to 111 select nothing. As a source they leave both enables at 0. As a destination they change no register.
- R6: Input function 00 loads bits 15:8 from the load source at the rising edge, and function 01 loads bits 7:0. The other byte is kept unchanged.
- R7: Input function 10 adds one and function 11 subtracts one over all 16 bits, with carry or borrow between the bytes. FFFF+1 gives 0000 and 0000-1 gives FFFF.
- R8: When `dbus_oe` is 1, the load source is `dbus_out` and `dbus_in` is ignored. Otherwise the load source is `dbus_in`. A low-to-high byte copy within one register finishes in one clock.
- R9: Output function 11 clears the selected register without waiting for a clock edge and drives neither bus. A clocked action on the same register in that cycle is overridden, and the register stays 0000.
- R10: A clocked action changes only the destination register. All other registers hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; input actions take effect on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_sel | input | 3 | Output-side register code |
| src_fn | input | 2 | Output-side action code |
| dst_sel | input | 3 | Input-side register code |
| dst_fn | input | 2 | Input-side action code |
| dbus_in | input | 8 | Byte arriving from the data bus |
| dbus_out | output | 8 | Byte the bank drives onto the data bus, 00 when not enabled |
| dbus_oe | output | 1 | Data-bus drive enable |
| abus_out | output | 16 | Value the bank drives onto the address bus, 0000 when not enabled |
| abus_oe | output | 1 | Address-bus drive enable |

## Verification
The bench uses the default parameters: 16-bit registers, 8-bit bytes, four registers, 3-bit codes and the asynchronous clear variant. These widths put the wrap at FFFF/0000 and the carry from byte to byte within reach of a few directed steps. With four registers under a 3-bit code, the reserved codes 101 to 111 stay unused and can be driven on both halves to show they select nothing. Same-register copies and clear-versus-increment collisions are driven directly, because the two halves of the control word are independent inputs.

// File: rtl/addr_bank_pkg.sv
`timescale 1ns/1ps
package addr_bank_pkg;
   typedef enum logic [1:0] {
      SRC_HI   = 2'b00,
      SRC_LO   = 2'b01,
      SRC_ADDR = 2'b10,
      SRC_CLR  = 2'b11
   } src_fn_e;

   typedef enum logic [1:0] {
      DST_HI  = 2'b00,
      DST_LO  = 2'b01,
      DST_INC = 2'b10,
      DST_DEC = 2'b11
   } dst_fn_e;
endpackage

// File: rtl/addr_bank_dec.sv
`timescale 1ns/1ps
module addr_bank_dec #(
   parameter int SEL_W    = 3,
   parameter int NUM_REGS = 4
) (
   input  logic [SEL_W-1:0]    code,
   output logic [NUM_REGS-1:0] hot
);
   // code 0 selects nothing; codes above NUM_REGS select nothing
   for (genvar i = 0; i < NUM_REGS; i++) begin : g_hot
      assign hot[i] = (code == SEL_W'(i + 1));
   end
endmodule

// File: rtl/addr_bank_cell.sv
`timescale 1ns/1ps
module addr_bank_cell
   import addr_bank_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int BYTE_W    = 8,
   parameter bit ASYNC_CLR = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [1:0]        fn,
   input  logic [BYTE_W-1:0] byte_in,
   output logic [ADDR_W-1:0] q
);
   logic [ADDR_W-1:0] nxt;
   dst_fn_e           op;

   assign op = dst_fn_e'(fn);

   always_comb begin
      unique case (op)
         DST_HI:  nxt = {byte_in, q[BYTE_W-1:0]};
         DST_LO:  nxt = {q[ADDR_W-1:BYTE_W], byte_in};
         DST_INC: nxt = q + ADDR_W'(1);
         DST_DEC: nxt = q - ADDR_W'(1);
         default: nxt = q;
      endcase
   end

   if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or posedge clr) begin
         if (clr)        q <= '0;
         else if (rst)   q <= '0;
         else if (wr_en) q <= nxt;
      end
   end else begin : g_sync
      always_ff @(posedge clk) begin
         if (rst || clr) q <= '0;
         else if (wr_en) q <= nxt;
      end
   end
endmodule

// File: rtl/addr_bank_out.sv
`timescale 1ns/1ps
module addr_bank_out
   import addr_bank_pkg::*;
#(
   parameter int NUM_REGS = 4,
   parameter int ADDR_W   = 16,
   parameter int BYTE_W   = 8
) (
   input  logic [NUM_REGS-1:0]             hot,
   input  logic [1:0]                      fn,
   input  logic [NUM_REGS-1:0][ADDR_W-1:0] regs,
   output logic [BYTE_W-1:0]               dbus_out,
   output logic                            dbus_oe,
   output logic [ADDR_W-1:0]               abus_out,
   output logic                            abus_oe,
   output logic [NUM_REGS-1:0]             clr_hot
);
   logic [ADDR_W-1:0] picked;
   logic              any_sel;
   src_fn_e           act;

   assign act     = src_fn_e'(fn);
   assign any_sel = |hot;

   always_comb begin
      picked = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (hot[i]) picked = picked | regs[i];
      end
   end

   assign dbus_oe  = any_sel && (act == SRC_HI || act == SRC_LO);
   assign abus_oe  = any_sel && (act == SRC_ADDR);
   assign dbus_out = !dbus_oe ? '0 :
                     (act == SRC_HI) ? picked[ADDR_W-1:BYTE_W] : picked[BYTE_W-1:0];
   assign abus_out = abus_oe ? picked : '0;
   assign clr_hot  = (act == SRC_CLR) ? hot : '0;
endmodule

// File: rtl/addr_reg_bank.sv
`timescale 1ns/1ps
module addr_reg_bank #(
   parameter int ADDR_W    = 16,
   parameter int BYTE_W    = 8,
   parameter int NUM_REGS  = 4,
   parameter int SEL_W     = 3,
   parameter bit ASYNC_CLR = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [SEL_W-1:0]  src_sel,
   input  logic [1:0]        src_fn,
   input  logic [SEL_W-1:0]  dst_sel,
   input  logic [1:0]        dst_fn,
   input  logic [BYTE_W-1:0] dbus_in,
   output logic [BYTE_W-1:0] dbus_out,
   output logic              dbus_oe,
   output logic [ADDR_W-1:0] abus_out,
   output logic              abus_oe
);
   localparam int MAX_CODE = (1 << SEL_W) - 1;

   if (ADDR_W != 2 * BYTE_W) begin : g_bad_width
      $error("addr_reg_bank: ADDR_W must be twice BYTE_W");
   end
   if (NUM_REGS < 1 || NUM_REGS > MAX_CODE) begin : g_bad_count
      $error("addr_reg_bank: NUM_REGS must fit in the nonzero codes of SEL_W");
   end

   logic [NUM_REGS-1:0]             src_hot;
   logic [NUM_REGS-1:0]             dst_hot;
   logic [NUM_REGS-1:0]             clr_hot;
   logic [NUM_REGS-1:0][ADDR_W-1:0] regs_q;
   logic [BYTE_W-1:0]               load_byte;

   addr_bank_dec #(.SEL_W(SEL_W), .NUM_REGS(NUM_REGS)) src_dec_i (
      .code (src_sel),
      .hot  (src_hot)
   );

   addr_bank_dec #(.SEL_W(SEL_W), .NUM_REGS(NUM_REGS)) dst_dec_i (
      .code (dst_sel),
      .hot  (dst_hot)
   );

   addr_bank_out #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) out_i (
      .hot      (src_hot),
      .fn       (src_fn),
      .regs     (regs_q),
      .dbus_out (dbus_out),
      .dbus_oe  (dbus_oe),
      .abus_out (abus_out),
      .abus_oe  (abus_oe),
      .clr_hot  (clr_hot)
   );

   // the bank's own driven byte wins over the external bus
   assign load_byte = dbus_oe ? dbus_out : dbus_in;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      addr_bank_cell #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .ASYNC_CLR(ASYNC_CLR)) cell_i (
         .clk     (clk),
         .rst     (rst),
         .clr     (clr_hot[i]),
         .wr_en   (dst_hot[i]),
         .fn      (dst_fn),
         .byte_in (load_byte),
         .q       (regs_q[i])
      );
   end
endmodule

// File: rtl/addr_bank_chk.sv
`timescale 1ns/1ps
module addr_bank_chk #(
   parameter int ADDR_W   = 16,
   parameter int BYTE_W   = 8,
   parameter int NUM_REGS = 4,
   parameter int SEL_W    = 3
) (
   input logic                            clk,
   input logic                            rst,
   input logic [SEL_W-1:0]                src_sel,
   input logic [1:0]                      src_fn,
   input logic [SEL_W-1:0]                dst_sel,
   input logic [1:0]                      dst_fn,
   input logic [BYTE_W-1:0]               dbus_out,
   input logic                            dbus_oe,
   input logic                            abus_oe,
   input logic [NUM_REGS-1:0][ADDR_W-1:0] regs_q,
   input logic [NUM_REGS-1:0]             clr_hot
);
   logic src_none;
   assign src_none = (src_sel == '0) || (int'(src_sel) > NUM_REGS);

   AST_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
      !(dbus_oe && abus_oe)); // R4

   AST_NONE_QUIET: assert property (@(posedge clk) disable iff (rst)
      src_none |-> (!dbus_oe && !abus_oe)); // R5

   AST_CLR_QUIET: assert property (@(posedge clk) disable iff (rst)
      (src_fn == 2'b11) |-> (!dbus_oe && !abus_oe)); // R9

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_per
      AST_INC_STEP: assert property (@(posedge clk) disable iff (rst)
         (dst_sel == SEL_W'(i + 1) && dst_fn == 2'b10 && !clr_hot[i])
         |=> (clr_hot[i] || regs_q[i] == ADDR_W'($past(regs_q[i]) + 1'b1))); // R7

      AST_DEC_STEP: assert property (@(posedge clk) disable iff (rst)
         (dst_sel == SEL_W'(i + 1) && dst_fn == 2'b11 && !clr_hot[i])
         |=> (clr_hot[i] || regs_q[i] == ADDR_W'($past(regs_q[i]) - 1'b1))); // R7

      AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (rst)
         (dst_sel == SEL_W'(i + 1) && dst_fn == 2'b01 && !clr_hot[i])
         |=> (clr_hot[i] || $stable(regs_q[i][ADDR_W-1:BYTE_W]))); // R6

      AST_COPY_SRC: assert property (@(posedge clk) disable iff (rst)
         (dbus_oe && dst_sel == SEL_W'(i + 1) && dst_fn == 2'b00 && !clr_hot[i])
         |=> (clr_hot[i] || regs_q[i][ADDR_W-1:BYTE_W] == $past(dbus_out))); // R8

      AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
         (dst_sel != SEL_W'(i + 1) && !clr_hot[i])
         |=> (clr_hot[i] || $stable(regs_q[i]))); // R10
   end
endmodule

bind addr_reg_bank addr_bank_chk #(
   .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)
) chk_i (
   .clk      (clk),
   .rst      (rst),
   .src_sel  (src_sel),
   .src_fn   (src_fn),
   .dst_sel  (dst_sel),
   .dst_fn   (dst_fn),
   .dbus_out (dbus_out),
   .dbus_oe  (dbus_oe),
   .abus_oe  (abus_oe),
   .regs_q   (regs_q),
   .clr_hot  (clr_hot)
);

// File: tb/addr_reg_bank_tb_top.sv
`timescale 1ns/1ps
module addr_reg_bank_tb_top;
   logic        clk = 1'b0;
   logic        rst;
   logic [2:0]  src_sel, dst_sel;
   logic [1:0]  src_fn, dst_fn;
   logic [7:0]  dbus_in;
   logic [7:0]  dbus_out;
   logic        dbus_oe;
   logic [15:0] abus_out;
   logic        abus_oe;

   int          n_cmp = 0;
   int          n_bad = 0;
   logic [15:0] exp_q [1:4];

   always #2.5 clk = ~clk;

   addr_reg_bank dut_i (
      .clk      (clk),
      .rst      (rst),
      .src_sel  (src_sel),
      .src_fn   (src_fn),
      .dst_sel  (dst_sel),
      .dst_fn   (dst_fn),
      .dbus_in  (dbus_in),
      .dbus_out (dbus_out),
      .dbus_oe  (dbus_oe),
      .abus_out (abus_out),
      .abus_oe  (abus_oe)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      n_cmp++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
      end
   endtask

   task automatic drive(input logic [2:0] ss, input logic [1:0] sf,
                        input logic [2:0] ds, input logic [1:0] df,
                        input logic [7:0] din);
      src_sel = ss; src_fn = sf; dst_sel = ds; dst_fn = df; dbus_in = din;
   endtask

   task automatic idle();
      drive(3'd0, 2'd0, 3'd0, 2'd0, 8'h00);
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic load16(input int r, input logic [15:0] v);
      drive(3'd0, 2'd0, 3'(r), 2'b00, v[15:8]); step();
      drive(3'd0, 2'd0, 3'(r), 2'b01, v[7:0]);  step();
      idle();
      exp_q[r] = v;
   endtask

   task automatic read16(input int r, output logic [15:0] v);
      drive(3'(r), 2'b10, 3'd0, 2'd0, 8'h00);
      #1;
      v = abus_out;
   endtask

   task automatic check_all(input string req);
      for (int r = 1; r <= 4; r++) begin
         logic [15:0] v;
         read16(r, v);
         chk(req, $sformatf("reg code %0d value", r), 32'(v), 32'(exp_q[r]));
      end
      idle();
   endtask

   task automatic t_reset();
      for (int r = 1; r <= 4; r++) exp_q[r] = 16'h0000;
      check_all("R1");
   endtask

   task automatic t_byte_load();
      load16(1, 16'h1234);
      load16(2, 16'hBEEF);
      load16(3, 16'h0F0F);
      load16(4, 16'hA5C3);
      check_all("R6");
      drive(3'd0, 2'd0, 3'd3, 2'b01, 8'h5A); step(); idle();
      exp_q[3] = 16'h0F5A;
      check_all("R6");
      drive(3'd0, 2'd0, 3'd4, 2'b00, 8'h77); step(); idle();
      exp_q[4] = 16'h77C3;
      check_all("R6");
   endtask

   task automatic t_bus_drive();
      for (int r = 1; r <= 4; r++) begin
         drive(3'(r), 2'b00, 3'd0, 2'd0, 8'hEE); #1;
         chk("R2", "dbus_oe", 32'(dbus_oe), 32'd1);
         chk("R2", "dbus_out high byte", 32'(dbus_out), 32'(exp_q[r][15:8]));
         chk("R2", "abus_oe", 32'(abus_oe), 32'd0);
         drive(3'(r), 2'b01, 3'd0, 2'd0, 8'hEE); #1;
         chk("R3", "dbus_oe", 32'(dbus_oe), 32'd1);
         chk("R3", "dbus_out low byte", 32'(dbus_out), 32'(exp_q[r][7:0]));
         chk("R3", "abus_oe", 32'(abus_oe), 32'd0);
         drive(3'(r), 2'b10, 3'd0, 2'd0, 8'hEE); #1;
         chk("R4", "abus_oe", 32'(abus_oe), 32'd1);
         chk("R4", "abus_out", 32'(abus_out), 32'(exp_q[r]));
         chk("R4", "dbus_oe", 32'(dbus_oe), 32'd0);
      end
      idle();
      step();
   endtask

   task automatic t_inc_dec();
      load16(1, 16'hFFFF);
      drive(3'd0, 2'd0, 3'd1, 2'b10, 8'h00); step(); idle();
      exp_q[1] = 16'h0000;
      check_all("R7");
      drive(3'd0, 2'd0, 3'd1, 2'b11, 8'h00); step(); idle();
      exp_q[1] = 16'hFFFF;
      check_all("R7");
      load16(2, 16'h00FF);
      drive(3'd0, 2'd0, 3'd2, 2'b10, 8'h00); step(); idle();
      exp_q[2] = 16'h0100;
      check_all("R7");
      drive(3'd0, 2'd0, 3'd2, 2'b11, 8'h00); step();
      step(); idle();
      exp_q[2] = 16'h00FE;
      check_all("R7");
      check_all("R10");
   endtask

   task automatic t_copy();
      load16(3, 16'h12AB);
      drive(3'd3, 2'b01, 3'd3, 2'b00, 8'h55); step(); idle();
      exp_q[3] = 16'hABAB;
      check_all("R8");
      load16(4, 16'hC3D4);
      drive(3'd4, 2'b00, 3'd1, 2'b01, 8'h11); step(); idle();
      exp_q[1] = {exp_q[1][15:8], 8'hC3};
      check_all("R8");
      drive(3'd0, 2'b00, 3'd2, 2'b00, 8'h66); step(); idle();
      exp_q[2] = {8'h66, exp_q[2][7:0]};
      check_all("R8");
   endtask

   task automatic t_clear();
      drive(3'd2, 2'b11, 3'd2, 2'b10, 8'h00); #1;
      chk("R9", "dbus_oe during clear", 32'(dbus_oe), 32'd0);
      chk("R9", "abus_oe during clear", 32'(abus_oe), 32'd0);
      step(); idle();
      exp_q[2] = 16'h0000;
      check_all("R9");
      drive(3'd4, 2'b11, 3'd0, 2'd0, 8'h00); step(); idle();
      exp_q[4] = 16'h0000;
      check_all("R9");
   endtask

   task automatic t_none();
      int codes[4] = '{0, 5, 6, 7};
      foreach (codes[k]) begin
         for (int f = 0; f < 4; f++) begin
            drive(3'(codes[k]), 2'(f), 3'd0, 2'd0, 8'h00); #1;
            chk("R5", $sformatf("dbus_oe code %0d fn %0d", codes[k], f), 32'(dbus_oe), 32'd0);
            chk("R5", $sformatf("abus_oe code %0d fn %0d", codes[k], f), 32'(abus_oe), 32'd0);
         end
         idle();
         step();
         drive(3'd0, 2'd0, 3'(codes[k]), 2'b10, 8'h00); step();
         drive(3'd0, 2'd0, 3'(codes[k]), 2'b00, 8'h77); step(); idle();
         check_all("R5");
      end
   endtask

   task automatic t_rerun_reset();
      rst = 1'b1; step(); rst = 1'b0;
      for (int r = 1; r <= 4; r++) exp_q[r] = 16'h0000;
      check_all("R1");
   endtask

   initial begin
      #1000000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      rst = 1'b1;
      idle();
      @(negedge clk);
      step();
      step();
      rst = 1'b0;
      t_reset();
      t_byte_load();
      t_bus_drive();
      t_inc_dec();
      t_copy();
      t_clear();
      t_none();
      load16(3, 16'h4321);
      t_rerun_reset();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule